// File: doc/BRIEF.md
# Configuration Image Loader Register Block

This block is the device-side register set that a host walks through, using 32-bit configuration-space reads and writes, to push a fabric configuration image into a device. It lives inside a vendor-specific extended capability, so every access carries a byte offset relative to that capability's base. A small set of registers is decoded: a read-only identifier, a read-only status word, a mode control word, a write-only data port, a program control word and an uncorrectable-error word whose configuration-error bit is sticky.

Toward the configuration engine the block drives the mode, clock-select, request and transfer-start levels, a one-cycle strobe with every data word, and a busy flag that stays high for the programmed number of configuration clocks per word. The engine returns a done level and an error level. From these, together with a static enable strap, the block builds the status flags the host polls: ready, done, error, user mode and fabric-clock-in-use.

The host must set the transceiver clock select before it sets configuration mode. The block enforces this order in hardware and does not trust the driver to keep it. A configuration error seen on the engine input is copied into the uncorrectable-error word. That copy stays set after the live flag drops, until the host clears it with a write-one.

Top module: `cfgload_regblk`

## Requirements
- R1: A read at offset 0x00 returns 0x0000000B, which is the capability identifier in the low 16 bits with the upper 16 bits zero.
- R2: A read at any offset other than 0x00, 0x1C, 0x20, 0x2C and 0x34 returns zero, and this includes the write-only data port at 0x28. A write to an unmapped offset changes no register and no output.
- R3: The status word at 0x1C reads bit 18 ready, bit 19 live error, bit 20 enable strap, bit 21 user mode, bit 23 done and bit 24 clock-in-use, with all other bits zero. Writes to it are ignored.
- R4: Ready (`o_ready`, status bit 18) rises one cycle after the request bit (program control bit 0) becomes 1, and it falls one cycle after that bit becomes 0.
- R5: In mode control (0x20), bit 1 is the clock select and bit 0 is configuration mode. A write that sets bit 0 takes effect only if bit 1 is already 1. Bit 1 cannot be cleared while bit 0 stays 1. A write that clears both clears both.
- R6: User mode and clock-in-use read 1 one cycle after both mode control bits 0 and 1 are 0. They read 0 one cycle after either bit is 1.
- R7: In the cycle after a write to 0x28, `data_stb` is high for exactly one cycle, and `data_word` carries the written value.
- R8: `data_busy` goes high in the same cycle as `data_stb` and stays high for N cycles, where N is mode control bits 15:8. A value of 0 counts as 1.
- R9: Bit 5 of 0x34 is set in the cycle after the engine error input is high. It stays set after the live error clears and is cleared by writing 1 to bit 5. If a clear and a new error arrive in the same cycle, the error wins.
- R10: Program control (0x2C) reads back bit 0 (request) and bit 1 (transfer start), and drives `eng_req` and `eng_xfer` with them. Mode control reads back bits 15:8, 1 and 0.
- R11: A read returns its data on `rd_data` with `rd_valid` high for one cycle, in the cycle after the access. The data is the register value at the access.
- R12: After reset all control bits, the clock count, the strobe, busy, ready, done, error and the sticky error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Static strap: the loading feature is enabled |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset from capability base |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| eng_done_in | input | 1 | Engine reports configuration done |
| eng_err_in | input | 1 | Engine reports configuration error |
| eng_mode | output | 1 | Configuration mode level |
| eng_clk_sel | output | 1 | Transceiver clock selected |
| eng_clks | output | NCLK_W | Clocks per data word as programmed |
| eng_req | output | 1 | Configuration request |
| eng_xfer | output | 1 | Transfer start |
| data_stb | output | 1 | One-cycle data word strobe |
| data_word | output | 32 | Data word for the engine |
| data_busy | output | 1 | Clock burst for the current word in progress |
| o_ready | output | 1 | Config ready flag |
| o_done | output | 1 | Config done flag |
| o_error | output | 1 | Live config error flag |
| o_usermode | output | 1 | User mode flag |
| o_clkinuse | output | 1 | Fabric clock in use flag |

## Verification
The embedded properties watch, on every cycle, the invariants that need no scenario. Configuration mode never stands without the clock select. A raised request is always followed by ready. Every data strobe comes with busy. The sticky error always covers the live one. User mode drops after either mode bit is set, and read data appears only right after a read. The ordering refusal, the burst length for each programmed count (with zero counted as one), the sticky error outliving the live flag together with its write-one clear, the ignored writes and the full status bit map can only be shown by the bench's sequences. Those sequences read back, through the register port, values computed from the requirements.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   localparam logic [11:0] OFS_CAPID  = 12'h000;
   localparam logic [11:0] OFS_STATUS = 12'h01C;
   localparam logic [11:0] OFS_MODE   = 12'h020;
   localparam logic [11:0] OFS_DATA   = 12'h028;
   localparam logic [11:0] OFS_PROG   = 12'h02C;
   localparam logic [11:0] OFS_UERR   = 12'h034;

   localparam int ST_READY  = 18;
   localparam int ST_ERROR  = 19;
   localparam int ST_ENABLE = 20;
   localparam int ST_USER   = 21;
   localparam int ST_DONE   = 23;
   localparam int ST_CLKUSE = 24;

   localparam int MD_MODE   = 0;
   localparam int MD_CLKSEL = 1;
   localparam int MD_NCLK_LSB = 8;
   localparam int MD_NCLK_MAXW = 8;

   localparam int PG_REQ  = 0;
   localparam int PG_XFER = 1;

   localparam int UE_CFGERR = 5;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CAPID,
      SEL_STATUS,
      SEL_MODE,
      SEL_DATA,
      SEL_PROG,
      SEL_UERR
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [11:0] ofs);
      logic [11:0] w;
      w = {ofs[11:2], 2'b00};
      if (w == OFS_CAPID)       return SEL_CAPID;
      else if (w == OFS_STATUS) return SEL_STATUS;
      else if (w == OFS_MODE)   return SEL_MODE;
      else if (w == OFS_DATA)   return SEL_DATA;
      else if (w == OFS_PROG)   return SEL_PROG;
      else if (w == OFS_UERR)   return SEL_UERR;
      else                      return SEL_NONE;
   endfunction

endpackage

// File: rtl/cfgl_mode_ctrl.sv
module cfgl_mode_ctrl #(
   parameter int NCLK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic              mode,
   output logic              clk_sel,
   output logic [NCLK_W-1:0] nclks
);
   import cfgl_pkg::*;

   logic next_mode;
   logic next_clk;

   always_comb begin
      // configuration mode may only be entered once the clock select stands
      next_mode = wdata[MD_MODE] & clk_sel;
      // clock select stays while configuration mode remains
      next_clk  = wdata[MD_CLKSEL] | next_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= 1'b0;
         clk_sel <= 1'b0;
         nclks   <= '0;
      end else if (wr_en) begin
         mode    <= next_mode;
         clk_sel <= next_clk;
         nclks   <= wdata[MD_NCLK_LSB +: NCLK_W];
      end
   end

   p_mode_needs_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode |-> clk_sel)
      else $error("R5: configuration mode without clock select");

   p_no_skip_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_sel && !mode) |=> !mode)
      else $error("R5: configuration mode entered before clock select");

endmodule

// File: rtl/cfgl_word_pacer.sv
module cfgl_word_pacer #(
   parameter int NCLK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic [NCLK_W-1:0] nclks,
   output logic              stb,
   output logic [31:0]       word,
   output logic              busy
);
   logic [NCLK_W-1:0] cnt;
   logic [NCLK_W-1:0] load_val;

   always_comb begin
      load_val = (nclks == '0) ? NCLK_W'(1) : nclks;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb  <= 1'b0;
         word <= '0;
         cnt  <= '0;
      end else begin
         stb <= wr_en;
         if (wr_en) begin
            word <= wdata;
            cnt  <= load_val;
         end else if (cnt != '0) begin
            cnt <= cnt - NCLK_W'(1);
         end
      end
   end

   assign busy = (cnt != '0);

   p_busy_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && cnt == NCLK_W'(1)) |=> !busy)
      else $error("R8: busy outlasted its count");

endmodule

// File: rtl/cfgl_status.sv
module cfgl_status (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic mode,
   input  logic clk_sel,
   input  logic done_in,
   input  logic err_in,
   input  logic err_clr,
   output logic ready,
   output logic done,
   output logic err,
   output logic user,
   output logic clkuse,
   output logic err_sticky
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready      <= 1'b0;
         done       <= 1'b0;
         err        <= 1'b0;
         user       <= 1'b0;
         clkuse     <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         ready  <= req;
         done   <= done_in;
         err    <= err_in;
         user   <= ~mode & ~clk_sel;
         clkuse <= ~mode & ~clk_sel;
         if (err_in)       err_sticky <= 1'b1;
         else if (err_clr) err_sticky <= 1'b0;
      end
   end

   p_sticky_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> err_sticky)
      else $error("R9: live error without sticky copy");

   p_user_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode || clk_sel) |=> (!user && !clkuse))
      else $error("R6: user mode while a mode bit is set");

endmodule

// File: rtl/cfgload_regblk.sv
module cfgload_regblk #(
   parameter int          ADDR_W  = 12,
   parameter int          NCLK_W  = 8,
   parameter logic [15:0] CAP_ID  = 16'h000B,
   parameter bit          RD_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_en,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [31:0]       acc_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   input  logic              eng_done_in,
   input  logic              eng_err_in,
   output logic              eng_mode,
   output logic              eng_clk_sel,
   output logic [NCLK_W-1:0] eng_clks,
   output logic              eng_req,
   output logic              eng_xfer,
   output logic              data_stb,
   output logic [31:0]       data_word,
   output logic              data_busy,
   output logic              o_ready,
   output logic              o_done,
   output logic              o_error,
   output logic              o_usermode,
   output logic              o_clkinuse
);
   import cfgl_pkg::*;

   if (ADDR_W < 6 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 6..12");
   end
   if (NCLK_W < 1 || NCLK_W > MD_NCLK_MAXW) begin : g_bad_nclk
      $error("NCLK_W must lie in 1..8");
   end

   reg_sel_e    sel;
   logic        wr;
   logic        rd;
   logic        err_sticky;
   logic [31:0] rd_next;

   always_comb begin
      sel = decode_ofs(12'(acc_addr));
      wr  = acc_valid &  acc_write;
      rd  = acc_valid & ~acc_write;
   end

   // program control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_req  <= 1'b0;
         eng_xfer <= 1'b0;
      end else if (wr && sel == SEL_PROG) begin
         eng_req  <= acc_wdata[PG_REQ];
         eng_xfer <= acc_wdata[PG_XFER];
      end
   end

   cfgl_mode_ctrl #(.NCLK_W(NCLK_W)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr && sel == SEL_MODE),
      .wdata   (acc_wdata),
      .mode    (eng_mode),
      .clk_sel (eng_clk_sel),
      .nclks   (eng_clks)
   );

   cfgl_word_pacer #(.NCLK_W(NCLK_W)) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr && sel == SEL_DATA),
      .wdata (acc_wdata),
      .nclks (eng_clks),
      .stb   (data_stb),
      .word  (data_word),
      .busy  (data_busy)
   );

   cfgl_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (eng_req),
      .mode       (eng_mode),
      .clk_sel    (eng_clk_sel),
      .done_in    (eng_done_in),
      .err_in     (eng_err_in),
      .err_clr    (wr && sel == SEL_UERR && acc_wdata[UE_CFGERR]),
      .ready      (o_ready),
      .done       (o_done),
      .err        (o_error),
      .user       (o_usermode),
      .clkuse     (o_clkinuse),
      .err_sticky (err_sticky)
   );

   always_comb begin
      rd_next = '0;
      unique case (sel)
         SEL_CAPID:  rd_next[15:0] = CAP_ID;
         SEL_STATUS: begin
            rd_next[ST_READY]  = o_ready;
            rd_next[ST_ERROR]  = o_error;
            rd_next[ST_ENABLE] = strap_en;
            rd_next[ST_USER]   = o_usermode;
            rd_next[ST_DONE]   = o_done;
            rd_next[ST_CLKUSE] = o_clkinuse;
         end
         SEL_MODE: begin
            rd_next[MD_MODE]   = eng_mode;
            rd_next[MD_CLKSEL] = eng_clk_sel;
            rd_next[MD_NCLK_LSB +: NCLK_W] = eng_clks;
         end
         SEL_PROG: begin
            rd_next[PG_REQ]  = eng_req;
            rd_next[PG_XFER] = eng_xfer;
         end
         SEL_UERR: rd_next[UE_CFGERR] = err_sticky;
         default:  rd_next = '0;
      endcase
   end

   if (RD_PIPE) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            rd_valid <= rd;
            rd_data  <= rd ? rd_next : '0;
         end
      end

      p_rdv_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(acc_valid && !acc_write))
         else $error("R11: read data without a read");
   end else begin : g_rd_comb
      always_comb begin
         rd_valid = rd;
         rd_data  = rd ? rd_next : '0;
      end
   end

   p_ready_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_req) |=> o_ready)
      else $error("R4: ready did not follow request");

   p_stb_with_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb |-> data_busy)
      else $error("R8: strobe without busy");

endmodule

// File: tb/sim_cfgload_regblk.sv
module sim_cfgload_regblk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_en = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        eng_done_in = 1'b0;
   logic        eng_err_in = 1'b0;
   logic        eng_mode, eng_clk_sel, eng_req, eng_xfer;
   logic [7:0]  eng_clks;
   logic        data_stb, data_busy;
   logic [31:0] data_word;
   logic        o_ready, o_done, o_error, o_usermode, o_clkinuse;

   int tests = 0;
   int fails = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   cfgload_regblk u0 (
      .clk(clk), .rst_n(rst_n), .strap_en(strap_en),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .eng_done_in(eng_done_in), .eng_err_in(eng_err_in),
      .eng_mode(eng_mode), .eng_clk_sel(eng_clk_sel), .eng_clks(eng_clks),
      .eng_req(eng_req), .eng_xfer(eng_xfer), .data_stb(data_stb),
      .data_word(data_word), .data_busy(data_busy), .o_ready(o_ready),
      .o_done(o_done), .o_error(o_error), .o_usermode(o_usermode),
      .o_clkinuse(o_clkinuse));

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected rd_valid", rd_data, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   function automatic logic [31:0] status_model(input bit rdy, input bit err,
         input bit en, input bit usr, input bit dn);
      logic [31:0] s;
      s = '0;
      s[18] = rdy; s[19] = err; s[20] = en; s[21] = usr; s[23] = dn; s[24] = usr;
      return s;
   endfunction

   initial begin
      #(8 * 150000);
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n;
      idle(3);
      rst_n = 1'b1;
      // R12 reset state, sampled before any edge out of reset
      check({eng_mode, eng_clk_sel, eng_req, eng_xfer, data_stb, data_busy,
             o_ready, o_done, o_error} == 9'b0, "R12 reset outputs",
            {23'b0, eng_mode, eng_clk_sel, eng_req, eng_xfer, data_stb,
             data_busy, o_ready, o_done, o_error}, 32'h0);
      check(eng_clks == 8'h0, "R12 reset clock count", {24'b0, eng_clks}, 32'h0);
      idle(1);
      rd(12'h034, 32'h0, "R12 sticky error clear after reset");
      rd(12'h020, 32'h0, "R12 mode control zero after reset");

      // R1 identifier
      rd(12'h000, 32'h0000_000B, "R1 capability id");

      // R3 status with strap off then on
      rd(12'h01C, status_model(0, 0, 0, 1, 0), "R3 status strap off");
      strap_en = 1'b1;
      rd(12'h01C, status_model(0, 0, 1, 1, 0), "R3 status strap on");
      wr(12'h01C, 32'hFFFF_FFFF);
      idle(1);
      rd(12'h01C, status_model(0, 0, 1, 1, 0), "R3 status write ignored");

      // R2 unmapped and write-only offsets
      rd(12'h004, 32'h0, "R2 unmapped 0x04");
      rd(12'h030, 32'h0, "R2 unmapped 0x30");
      rd(12'h028, 32'h0, "R2 data port reads zero");
      wr(12'h024, 32'hFFFF_FFFF);
      wr(12'h030, 32'hFFFF_FFFF);
      idle(1);
      check({eng_mode, eng_clk_sel, eng_req, eng_xfer, data_stb} == 5'b0,
            "R2 unmapped write ignored outputs",
            {27'b0, eng_mode, eng_clk_sel, eng_req, eng_xfer, data_stb}, 32'h0);
      rd(12'h020, 32'h0, "R2 mode unchanged after unmapped write");
      rd(12'h02C, 32'h0, "R2 prog unchanged after unmapped write");

      // R4 ready follows request
      wr(12'h02C, 32'h1);
      check(o_ready == 1'b0, "R4 ready not yet", {31'b0, o_ready}, 32'h0);
      idle(1);
      check(o_ready == 1'b1, "R4 ready risen", {31'b0, o_ready}, 32'h1);
      rd(12'h01C, status_model(1, 0, 1, 1, 0), "R3 R4 status ready bit");
      wr(12'h02C, 32'h3);
      check(eng_xfer == 1'b1 && eng_req == 1'b1, "R10 xfer drive",
            {30'b0, eng_xfer, eng_req}, 32'h3);
      rd(12'h02C, 32'h3, "R10 prog readback");
      wr(12'h02C, 32'h0);
      check(o_ready == 1'b1, "R4 ready not yet fallen", {31'b0, o_ready}, 32'h1);
      idle(1);
      check(o_ready == 1'b0, "R4 ready fallen", {31'b0, o_ready}, 32'h0);

      // R5 ordering, R6 user mode
      wr(12'h020, 32'h0000_0003);
      check(eng_mode == 1'b0 && eng_clk_sel == 1'b1, "R5 mode refused before clksel",
            {30'b0, eng_clk_sel, eng_mode}, 32'h2);
      idle(1);
      check(o_usermode == 1'b0 && o_clkinuse == 1'b0, "R6 user off with clksel",
            {30'b0, o_clkinuse, o_usermode}, 32'h0);
      wr(12'h020, 32'h0000_0503);
      check(eng_mode == 1'b1 && eng_clk_sel == 1'b1, "R5 mode accepted",
            {30'b0, eng_clk_sel, eng_mode}, 32'h3);
      rd(12'h020, 32'h0000_0503, "R10 mode readback");
      wr(12'h020, 32'h0000_0501);
      check(eng_clk_sel == 1'b1 && eng_mode == 1'b1, "R5 clksel held under mode",
            {30'b0, eng_clk_sel, eng_mode}, 32'h3);
      wr(12'h020, 32'h0000_0000);
      check(eng_clk_sel == 1'b0 && eng_mode == 1'b0, "R5 both cleared",
            {30'b0, eng_clk_sel, eng_mode}, 32'h0);
      check(o_usermode == 1'b0, "R6 user not yet", {31'b0, o_usermode}, 32'h0);
      idle(1);
      check(o_usermode == 1'b1 && o_clkinuse == 1'b1, "R6 user and clk in use",
            {30'b0, o_clkinuse, o_usermode}, 32'h3);

      // R7 R8 data strobe and busy burst
      wr(12'h020, 32'h0000_0400);
      wr(12'h028, 32'hDEAD_BEEF);
      check(data_stb == 1'b1, "R7 strobe high", {31'b0, data_stb}, 32'h1);
      check(data_word == 32'hDEAD_BEEF, "R7 data word", data_word, 32'hDEAD_BEEF);
      n = 0;
      while (data_busy && n < 300) begin
         n++;
         @(negedge clk);
         if (n == 1) check(data_stb == 1'b0, "R7 strobe single cycle",
                           {31'b0, data_stb}, 32'h0);
      end
      check(n == 4, "R8 busy for four clocks", n, 32'd4);
      wr(12'h020, 32'h0000_0000);
      wr(12'h028, 32'h1234_5678);
      n = 0;
      while (data_busy && n < 300) begin n++; @(negedge clk); end
      check(n == 1, "R8 zero count as one", n, 32'd1);
      wr(12'h020, 32'h0000_0200);
      wr(12'h028, 32'h1);
      idle(1);
      wr(12'h028, 32'h2);
      check(data_word == 32'h2 && data_stb, "R7 second word", data_word, 32'h2);
      n = 0;
      while (data_busy && n < 300) begin n++; @(negedge clk); end
      check(n == 2, "R8 restart on new word", n, 32'd2);

      // R9 sticky error
      eng_err_in = 1'b1;
      idle(1);
      check(o_error == 1'b1, "R9 live error", {31'b0, o_error}, 32'h1);
      eng_err_in = 1'b0;
      idle(2);
      check(o_error == 1'b0, "R9 live error cleared", {31'b0, o_error}, 32'h0);
      rd(12'h01C, status_model(0, 0, 1, 1, 0), "R3 R9 status live error off");
      rd(12'h034, 32'h20, "R9 sticky held");
      wr(12'h034, 32'h0);
      rd(12'h034, 32'h20, "R9 write zero keeps sticky");
      eng_err_in = 1'b1;
      wr(12'h034, 32'h20);
      eng_err_in = 1'b0;
      rd(12'h034, 32'h20, "R9 error wins over clear");
      wr(12'h034, 32'h20);
      rd(12'h034, 32'h0, "R9 write one clears");

      // done flag
      eng_done_in = 1'b1;
      idle(1);
      check(o_done == 1'b1, "R3 done flag", {31'b0, o_done}, 32'h1);
      rd(12'h01C, status_model(0, 0, 1, 1, 1), "R3 status done bit");

      // R11 back-to-back reads
      rd(12'h000, 32'h0000_000B, "R11 back to back a");
      rd(12'h02C, 32'h0, "R11 back to back b");
      idle(3);
      check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule